// File: doc/BRIEF.md
# Sixteen-Stage Pseudorandom Serial Bit Generator

This block produces a repeatable pseudorandom serial test-data stream from a sixteen-stage feedback shift register. It runs in a fast system clock domain. It is paced by a much slower external bit clock, nominally a 100 Hz square wave, that has no fixed phase relation to the system clock.

The external bit clock first passes through a two-flop synchroniser, and its falling edges are detected in the system domain. Each detected falling edge applies exactly one shift-and-feedback step. In a step, every stage takes the value of the stage above it. The top stage receives the XOR of four low-order stages. The serial output is a registered copy of the new bottom stage. A synchronous reset loads a fixed non-zero seed. The full state vector is also brought out so that a bench can observe it.

Top module: `prbs16_gen`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, `state_out` loads 16'h0001 (bit 0 set, bits 1 to 15 clear) and `data_out` loads 1.
- R2: In each step, `state_out[i]` takes the old `state_out[i+1]` for i from 0 to 14.
- R3: In each step, `state_out[15]` takes the XOR of the old `state_out` bits 0, 1, 3 and 12.
- R4: A rising edge of `bit_clk_in`, or a level held steady, leaves `state_out` and `data_out` unchanged.
- R5: A fall of `bit_clk_in` shows on `state_out` and `data_out` at the third rising `clk` edge that samples the low level. The first two such edges leave both outputs unchanged.
- R6: Each falling edge of `bit_clk_in` gives exactly one step, however long the low level is held, and two steps are never on consecutive `clk` cycles.
- R7: After every step, `data_out` equals the new `state_out[0]`.
- R8: `state_out` is never all zeros, checked over more than 70000 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_clk_in | input | 1 | External bit clock, asynchronous to `clk` |
| data_out | output | 1 | Registered serial pseudorandom bit |
| state_out | output | 16 | Current contents of the sixteen stages |

## Verification
The bench builds the block with its default parameters: a 16-bit register, tap mask 16'h100B, seed 16'h0001 and two synchroniser stages. With these values a bit clock that toggles on every system cycle is still seen cleanly, so a bit-clock period of two cycles brings more than 70000 steps within reach of a short run. Over that run the state is compared with a bench-side recurrence and is checked against the all-zero value. A table of bit-clock duty patterns, ranging from single-cycle pulses to long holds, covers the edge detector's timing.

// File: rtl/prbs16_pkg.sv
package prbs16_pkg;
    localparam int          GEN_W     = 16;
    localparam logic [15:0] GEN_SEED  = 16'h0001;
    // feedback stages 0, 1, 3 and 12
    localparam logic [15:0] GEN_TAPS  = 16'h100B;
    localparam int          GEN_SYNC  = 2;
endpackage

// File: rtl/bitclk_fall_det.sv
module bitclk_fall_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic fall_pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } det_regs_t;

    det_regs_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.sync = {det_q.sync[SYNC_STAGES-2:0], async_in};
        det_d.prev = det_q.sync[LAST];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign fall_pulse = det_q.prev & ~det_q.sync[LAST];
endmodule

// File: rtl/lfsr_next.sv
module lfsr_next #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS  = 16'h100B
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH - 1; gi++) begin : g_shift
            assign nxt[gi] = cur[gi+1];
        end
    endgenerate

    assign nxt[WIDTH-1] = ^(cur & TAPS);
endmodule

// File: rtl/prbs16_gen.sv
module prbs16_gen #(
    parameter int               WIDTH       = prbs16_pkg::GEN_W,
    parameter logic [WIDTH-1:0] SEED        = prbs16_pkg::GEN_SEED,
    parameter logic [WIDTH-1:0] TAPS        = prbs16_pkg::GEN_TAPS,
    parameter int               SYNC_STAGES = prbs16_pkg::GEN_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_clk_in,
    output logic             data_out,
    output logic [WIDTH-1:0] state_out
);
    typedef struct packed {
        logic [WIDTH-1:0] stages;
        logic             dout;
    } gen_regs_t;

    localparam gen_regs_t RESET_VAL = '{stages: SEED, dout: SEED[0]};

    gen_regs_t        gen_d, gen_q;
    logic             step_en;
    logic [WIDTH-1:0] stepped;

    bitclk_fall_det #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_det (
        .clk        (clk),
        .rst        (rst),
        .async_in   (bit_clk_in),
        .fall_pulse (step_en)
    );

    lfsr_next #(
        .WIDTH (WIDTH),
        .TAPS  (TAPS)
    ) u_next (
        .cur (gen_q.stages),
        .nxt (stepped)
    );

    always_comb begin
        gen_d = gen_q;
        if (step_en) begin
            gen_d.stages = stepped;
            gen_d.dout   = stepped[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q <= RESET_VAL;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign data_out  = gen_q.dout;
    assign state_out = gen_q.stages;
endmodule

// File: rtl/prbs16_gen_chk.sv
module prbs16_gen_chk #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] SEED  = 16'h0001,
    parameter logic [WIDTH-1:0] TAPS  = 16'h100B
) (
    input logic             clk,
    input logic             rst,
    input logic             data_out,
    input logic [WIDTH-1:0] state_out
);
    // R1
    a_r1_seed_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_out == SEED && data_out == SEED[0]));

    // R8
    a_r8_never_zero: assert property (@(posedge clk) disable iff (rst)
        state_out != '0);

    // R2
    a_r2_shift_down: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && state_out != $past(state_out))
        |-> state_out[WIDTH-2:0] == $past(state_out[WIDTH-1:1]));

    // R3
    a_r3_feedback: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && state_out != $past(state_out))
        |-> state_out[WIDTH-1] == ^($past(state_out) & TAPS));

    // R6
    a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && state_out != $past(state_out))
        |=> $stable(state_out));

    // R7
    a_r7_out_is_bottom: assert property (@(posedge clk) disable iff (rst)
        data_out == state_out[0]);
endmodule

bind prbs16_gen prbs16_gen_chk #(
    .WIDTH (WIDTH),
    .SEED  (SEED),
    .TAPS  (TAPS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .data_out  (data_out),
    .state_out (state_out)
);

// File: tb/sim_prbs16_gen.sv
module sim_prbs16_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b1;
    logic        dout;
    logic [15:0] st;

    int          checks = 0;
    int          fails  = 0;
    logic [15:0] model;
    bit          done = 1'b0;

    typedef struct packed {
        int hi;
        int lo;
        int pulses;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{hi: 10, lo: 10, pulses: 3},
        '{hi: 1,  lo: 1,  pulses: 8},
        '{hi: 2,  lo: 1,  pulses: 6},
        '{hi: 1,  lo: 3,  pulses: 5},
        '{hi: 40, lo: 2,  pulses: 2},
        '{hi: 3,  lo: 25, pulses: 4}
    };

    always #2 clk = ~clk;

    prbs16_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .bit_clk_in (bclk),
        .data_out   (dout),
        .state_out  (st)
    );

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[0] ^ s[1] ^ s[3] ^ s[12], s[15:1]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 195000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int zero_hits;
        int out_miss;
        tick(3);
        rst = 1'b0;
        tick(1);
        model = 16'h0001;
        chk("R1 reset state", {16'h0, st}, {16'h0, 16'h0001});
        chk("R1 reset data_out", {31'h0, dout}, 32'h1);

        // table of bit-clock patterns: R2 R3 R7
        for (int v = 0; v < NVEC; v++) begin
            for (int p = 0; p < VECS[v].pulses; p++) begin
                bclk = 1'b1;
                tick(VECS[v].hi);
                bclk = 1'b0;
                tick(VECS[v].lo);
                model = step(model);
            end
            tick(4);
            chk("R2 R3 state after pattern", {16'h0, st}, {16'h0, model});
            chk("R7 data_out after pattern", {31'h0, dout}, {31'h0, model[0]});
        end

        // R4: rising edge and steady high do nothing
        bclk = 1'b1;
        tick(12);
        chk("R4 rising edge ignored", {16'h0, st}, {16'h0, model});
        chk("R4 data_out held", {31'h0, dout}, {31'h0, model[0]});

        // R5: latency of a fall
        bclk = 1'b0;
        tick(2);
        chk("R5 unchanged after two samples", {16'h0, st}, {16'h0, model});
        tick(1);
        model = step(model);
        chk("R5 step on third sample", {16'h0, st}, {16'h0, model});
        chk("R5 data_out on third sample", {31'h0, dout}, {31'h0, model[0]});

        // R6: long low gives only one step
        tick(60);
        chk("R6 single step on long low", {16'h0, st}, {16'h0, model});

        // R8: long run at fastest bit clock
        zero_hits = 0;
        out_miss  = 0;
        for (int n = 0; n < 70500; n++) begin
            bclk = 1'b1;
            tick(1);
            if (st == 16'h0) zero_hits++;
            if (dout !== st[0]) out_miss++;
            bclk = 1'b0;
            tick(1);
            if (st == 16'h0) zero_hits++;
            if (dout !== st[0]) out_miss++;
            model = step(model);
        end
        tick(4);
        chk("R8 zero state count", zero_hits, 0);
        chk("R7 data_out mismatch count", out_miss, 0);
        chk("R8 state after long run", {16'h0, st}, {16'h0, model});

        // R1: reset in mid-run
        bclk = 1'b1;
        rst  = 1'b1;
        tick(1);
        rst = 1'b0;
        chk("R1 mid-run reset state", {16'h0, st}, {16'h0, 16'h0001});
        chk("R1 mid-run reset data_out", {31'h0, dout}, 32'h1);
        tick(6);
        chk("R4 no step after reset with high clock", {16'h0, st}, {16'h0, 16'h0001});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule